// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It works on one multiplier bit per clock. A single 2N-bit shift register holds both the partial product and the multiplier. Its upper half accumulates sums. Its lower half starts out holding the multiplier. Each step inspects the lowest bit of the register. If that bit is set, the multiplicand is added into the upper half by an adder only N bits wide plus a carry. The register then shifts right by one place, and the carry becomes the new top bit. Finished low-order product bits enter the lower half from above as the spent multiplier bits drop out at the bottom.

A client drives the operands and raises `start_i` while `busy_o` is low. The block then runs for exactly N cycles and pulses `done_o` for one cycle. At that point `product_o` holds the result, and it stays there until the next accepted start. The operand width N is a parameter with a default of 8.

Top module: `shamul_top`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `product_o` is all zeros.
- R2: A start seen while `busy_o` is low is accepted. On the next cycle `busy_o` is 1, `product_o[2N-1:N]` is zero and `product_o[N-1:0]` equals the multiplier operand.
- R3: `done_o` rises exactly N clock cycles after the accepting edge. It stays high for one cycle, and `busy_o` is low in that cycle.
- R4: When `done_o` is high, `product_o` equals the unsigned product of the multiplicand and multiplier captured at acceptance, as a 2N-bit value.
- R5: A start raised while `busy_o` is high is ignored. The operation in flight and its result are unchanged, and so is its completion time.
- R6: While the block is idle and no start is present, `product_o` holds its value.
- R7: The adder carry-out is kept as the new top bit on each shift, so all-ones times all-ones gives 2^(2N) - 2^(N+1) + 1. For N=8 this is 0xFE01.
- R8: A zero operand on either side gives a zero product. An all-ones operand times one gives the all-ones value in the low half and zero in the upper half.
- R9: With N=4, 4'b1101 times 4'b1011 gives 8'b10001111 (143).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | N | Multiplicand, sampled at acceptance |
| mplier_i | input | N | Multiplier, sampled at acceptance |
| busy_o | output | 1 | High while add/shift steps are running |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2N | Combined shift register, holding the final product after done |

## Verification
Every cycle, the bound checker checks the following. The done pulse lasts one cycle and never overlaps busy. A counter confirms that done arrives after exactly N busy cycles. An accepted start must load a cleared upper half over the multiplier. The output must hold while idle. At each done, the product must match the operands captured at acceptance. Only the bench scenarios show specific arithmetic corner values: the carry-heavy all-ones case, zero operands, the 4-bit worked example, and a start pulsed mid-operation with different operands. Those scenarios show that the result and the timing still match the first request.

// File: rtl/shamul_pkg.sv
package shamul_pkg;

    typedef struct packed {
        logic busy;
        logic done;
    } ctl_flags_t;

    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/shamul_ctrl.sv
module shamul_ctrl
    import shamul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = cnt_width(N);

    typedef struct packed {
        logic [CW-1:0] cnt;
        ctl_flags_t    flg;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        st_d           = st_q;
        st_d.flg.done  = 1'b0;
        accept         = start_i && !st_q.flg.busy;
        if (accept) begin
            st_d.flg.busy = 1'b1;
            st_d.cnt      = CW'(N);
        end else if (st_q.flg.busy) begin
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.flg.busy = 1'b0;
                st_d.flg.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o = accept;
    assign step_o = st_q.flg.busy;
    assign busy_o = st_q.flg.busy;
    assign done_o = st_q.flg.done;

endmodule

// File: rtl/shamul_dp.sv
module shamul_dp #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic [2*N-1:0] acc_o
);
    localparam int W = 2 * N;

    typedef struct packed {
        logic [W-1:0] acc;
        logic [N-1:0] mcand;
    } dp_state_t;

    dp_state_t    dp_d, dp_q;
    logic [N:0]   addend;
    logic [N:0]   sum;

    always_comb begin
        dp_d   = dp_q;
        addend = dp_q.acc[0] ? {1'b0, dp_q.mcand} : '0;
        sum    = {1'b0, dp_q.acc[W-1:N]} + addend;
        if (load_i) begin
            dp_d.acc   = {{N{1'b0}}, mplier_i};
            dp_d.mcand = mcand_i;
        end else if (step_i) begin
            dp_d.acc = {sum, dp_q.acc[N-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign acc_o = dp_q.acc;

endmodule

// File: rtl/shamul_top.sv
module shamul_top #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*N-1:0] product_o
);
    logic load, step;

    shamul_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    shamul_dp #(.N(N)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .mcand_i  (mcand_i),
        .mplier_i (mplier_i),
        .acc_o    (product_o)
    );

endmodule

// File: rtl/shamul_chk.sv
module shamul_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [N-1:0]   mcand_i,
    input logic [N-1:0]   mplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*N-1:0] product_o
);
    int unsigned    busy_cnt;
    logic [2*N-1:0] want;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= 0;
            want     <= '0;
        end else if (start_i && !busy_o) begin
            busy_cnt <= 0;
            want     <= (2*N)'(mcand_i) * (2*N)'(mplier_i);
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    assert_accept_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && product_o[2*N-1:N] == '0
                                  && product_o[N-1:0] == $past(mplier_i)));

    assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == N));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    assert_product_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == want));

    assert_busy_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));

endmodule

bind shamul_top shamul_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/shamul_top_tb.sv
module shamul_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N-1:0] a = '0, b = '0;
    logic busy, done;
    logic [2*N-1:0] prod;

    logic start4 = 1'b0;
    logic [3:0] a4 = '0, b4 = '0;
    logic busy4, done4;
    logic [7:0] prod4;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    logic [2*N-1:0] exp_q[$];
    int             stamp_q[$];
    logic [2*N-1:0] last_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shamul_top #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mcand_i(a), .mplier_i(b),
        .busy_o(busy), .done_o(done), .product_o(prod)
    );

    shamul_top #(.N(4)) u_dut_n4 (
        .clk(clk), .rst_n(rst_n), .start_i(start4), .mcand_i(a4), .mplier_i(b4),
        .busy_o(busy4), .done_o(done4), .product_o(prod4)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: pops scoreboard on each done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3 unexpected done", 32'(prod), 0);
            end else begin
                logic [2*N-1:0] e;
                int s;
                e = exp_q.pop_front();
                s = stamp_q.pop_front();
                chk(prod == e, "R4 product", 32'(prod), 32'(e));
                chk(cyc - s == N, "R3 latency", 32'(cyc - s), N);
                chk(!busy, "R3 busy low at done", 32'(busy), 0);
            end
        end
    end

    // driver: starts one multiply and pushes its expectation
    task automatic run(input logic [N-1:0] x, input logic [N-1:0] y,
                       input bit poke_busy);
        @(negedge clk);
        while (busy) @(negedge clk);
        a = x; b = y; start = 1'b1;
        last_exp = (2*N)'(x) * (2*N)'(y);
        exp_q.push_back(last_exp);
        @(negedge clk);
        stamp_q.push_back(cyc);
        start = 1'b0;
        chk(busy && prod[2*N-1:N] == '0 && prod[N-1:0] == y, "R2 load",
            32'(prod), 32'(y));
        if (poke_busy) begin
            @(negedge clk);
            a = ~x; b = ~y; start = 1'b1;   // R5: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && prod == '0, "R1 reset", 32'(prod), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && prod == '0, "R1 after release", 32'(prod), 0);

        run(8'd13, 8'd11, 0);
        run(8'hFF, 8'hFF, 0);
        chk(prod == 16'hFE01, "R7 all-ones squared", 32'(prod), 32'hFE01);
        run(8'h00, 8'hA5, 0);
        chk(prod == '0, "R8 zero multiplicand", 32'(prod), 0);
        run(8'h5A, 8'h00, 0);
        chk(prod == '0, "R8 zero multiplier", 32'(prod), 0);
        run(8'hFF, 8'h01, 0);
        chk(prod == 16'h00FF, "R8 all-ones times one", 32'(prod), 32'h00FF);
        run(8'h01, 8'hFF, 0);
        chk(prod == 16'h00FF, "R8 one times all-ones", 32'(prod), 32'h00FF);

        run(8'h37, 8'hC4, 1);
        chk(prod == 16'(8'h37 * 16'hC4), "R5 start during busy ignored",
            32'(prod), 32'(16'h37 * 16'hC4));

        repeat (4) @(negedge clk);
        chk(prod == last_exp, "R6 hold while idle", 32'(prod), 32'(last_exp));

        for (int i = 0; i < 20; i++) begin
            run(8'((i * 37 + 11) & 255), 8'((i * 91 + 200) & 255), 0);
        end

        // R9: 4-bit worked example on the narrow instance
        @(negedge clk);
        a4 = 4'b1101; b4 = 4'b1011; start4 = 1'b1;
        @(negedge clk);
        start4 = 1'b0;
        repeat (3) @(negedge clk);
        chk(!done4, "R9 no early done", 32'(done4), 0);
        @(negedge clk);
        chk(done4 && prod4 == 8'b10001111, "R9 13x11", 32'(prod4), 32'h8F);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule